// File: doc/BRIEF.md
# Byte-port packet mailbox controller

This block passes whole packets, one at a time, between a host processor and a network-side byte stream. The host sees a small word-addressed register window. Two of its registers are one-byte data ports: the host drains a received packet one byte per read and fills an outgoing packet one byte per write. Alongside them sit a receive byte count that counts itself down, a transmit byte count, an interrupt control register and a read-only interrupt line index.

On the network side, received frames arrive on a byte-wide valid/ready stream with an end-of-frame marker, and outgoing frames leave on a second stream of the same kind. Each direction has its own internal packet buffer of parameterized depth. A level interrupt tells the host that a frame has arrived, that a transmission has finished, or that a self-test request is pending.

The host handler reads the interrupt control register and acts on the flags it finds. For a receive, it reads the count and then that many bytes, and writes 1 to the receive flag. For a transmit, it writes the length and then the bytes, and waits for the tx-done flag.

Top module: `pkt_mailbox`

## Requirements
- R1: A read request returns its data on `bus_rdata_o` one clock later. The byte offsets are: busy flag 0x08 (bit 0), rx count 0x0C, tx count 0x10, interrupt control 0x14, interrupt info 0x18, rx data port 0x1C, tx data port 0x20. Any other offset reads 0.
- R2: The data ports use only bits 7:0 of the word. Bits 31:8 read as 0 on the rx port and are ignored when the host writes the tx port.
- R3: When the last byte of a received frame is accepted, the rx count is loaded with the frame length in bytes and interrupt control bit 1 (rx available) is set.
- R4: Each read of the rx data port returns the next byte of the frame, starting with the first, and lowers the rx count by one. When the rx count is 0, a read returns 0x00 and the count stays 0.
- R5: While bit 1 is set, `rx_ready_o` is low and no further frame is accepted. Writing 1 to bit 1 clears the flag, zeroes the rx count and raises `rx_ready_o` again.
- R6: A frame longer than RX_DEPTH bytes is consumed in full and then discarded. Neither bit 1 nor the rx count changes. A frame of exactly RX_DEPTH bytes is delivered.
- R7: A write to the tx count takes effect only while the tx count is 0 and the value is between 1 and TX_DEPTH. Nothing is sent until that many bytes have been written. The bytes then leave in write order, with `tx_last_o` on the final byte, and they hold steady while `tx_ready_i` is low. Data-port writes beyond the count are ignored.
- R8: When the last tx byte is handed off, the tx count becomes 0 and interrupt control bit 0 (tx done) is set.
- R9: Writing 1 to bit 0 or bit 1 of interrupt control clears only that bit. Writing 0 to a status bit leaves it unchanged.
- R10: Writing 1 to bit 31 sets a test flag and a test interrupt request. The first read of interrupt control shows bit 31 as 1, and later reads show it as 0. The request stays up until the host writes 0x00000000 to interrupt control.
- R11: The busy flag reads 1 while a frame is being received (first byte accepted, last byte not yet accepted) or transmitted (from the last host byte write until the last byte is handed off), and 0 otherwise.
- R12: The interrupt info register reads the constant parameter IRQ_LINE, and writes to it have no effect.
- R13: `irq_o` is high exactly when tx done, rx available or the test request is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Host access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the request |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_last_i | input | 1 | Byte is the last of its frame |
| rx_ready_o | output | 1 | Block accepts a received byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Byte is the last of the packet |
| tx_ready_i | input | 1 | Network side takes the transmit byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench first drains a received frame partway and checks the count after each read. It then reads an empty port and expects 0x00 with the count still 0; a count that wrapped below zero would show up here as a huge value. It offers frames while rx available is set, sends a frame one byte over the buffer depth and one of exactly the depth, and checks that only the oversized frame disappears. An off-by-one overflow test would either drop the full-depth frame or deliver a corrupted one. On transmit, the output stream is stalled with backpressure and extra data-port writes, and a queue model of the stream catches a byte that leaves early, is repeated or is lost. The self-test bit is read twice and the request is cleared by writing zero, which exposes a flag that never clears on read or an interrupt that is dropped too soon.

// File: rtl/pkt_mailbox_pkg.sv
package pkt_mailbox_pkg;
  localparam int OFS_BUSY   = 'h08;
  localparam int OFS_RXCNT  = 'h0C;
  localparam int OFS_TXCNT  = 'h10;
  localparam int OFS_INTCTL = 'h14;
  localparam int OFS_INFO   = 'h18;
  localparam int OFS_RXDATA = 'h1C;
  localparam int OFS_TXDATA = 'h20;
  localparam int INT_TXDONE = 0;
  localparam int INT_RXAVL  = 1;
  localparam int INT_TEST   = 31;
  localparam int MAX_COUNT  = 65536;
endpackage

// File: rtl/pmb_rx_path.sv
module pmb_rx_path #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  input  logic             rd_en_i,
  input  logic             release_i,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             held_o,
  output logic             active_o
);
  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] wr_cnt_q, cnt_q;
  logic [IDX_W-1:0] rd_ptr_q;
  logic             drop_q, held_q;
  logic             hs, full, frame_ok;

  assign s_ready_o = !held_q;
  assign hs        = s_valid_i && s_ready_o;
  assign full      = (wr_cnt_q == CNT_W'(DEPTH));
  assign frame_ok  = hs && s_last_i && !drop_q && !full;

  always_ff @(posedge clk_i) begin
    if (hs && !drop_q && !full) mem[wr_cnt_q[IDX_W-1:0]] <= s_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q <= '0;
      cnt_q    <= '0;
      rd_ptr_q <= '0;
      drop_q   <= 1'b0;
      held_q   <= 1'b0;
    end else begin
      if (release_i) begin
        held_q <= 1'b0;
        cnt_q  <= '0;
      end else if (rd_en_i && cnt_q != '0) begin
        cnt_q    <= cnt_q - CNT_W'(1);
        rd_ptr_q <= rd_ptr_q + IDX_W'(1);
      end
      if (hs) begin
        if (s_last_i) begin
          wr_cnt_q <= '0;
          drop_q   <= 1'b0;
          if (frame_ok) begin
            held_q   <= 1'b1;
            cnt_q    <= wr_cnt_q + CNT_W'(1);
            rd_ptr_q <= '0;
          end
        end else if (drop_q || full) begin
          drop_q <= 1'b1;
        end else begin
          wr_cnt_q <= wr_cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign byte_o   = (cnt_q != '0) ? mem[rd_ptr_q] : 8'h00;
  assign cnt_o    = cnt_q;
  assign held_o   = held_q;
  assign active_o = (wr_cnt_q != '0) || drop_q;

  assert_rx_count_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && cnt_q != '0 && !release_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_frame_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_q) |-> ($past(s_valid_i && s_last_i) && cnt_q != '0 && cnt_q <= CNT_W'(DEPTH)));

  assert_no_accept_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !release_i) |=> $stable(wr_cnt_q) && !drop_q);
endmodule

// File: rtl/pmb_tx_path.sv
module pmb_tx_path #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [31:0]      cnt_wdata_i,
  input  logic             byte_we_i,
  input  logic [7:0]       byte_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             m_valid_o,
  output logic [7:0]       m_data_o,
  output logic             m_last_o,
  input  logic             m_ready_i,
  output logic             done_o,
  output logic             sending_o
);
  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt_q, wr_q;
  logic [IDX_W-1:0] rd_q;
  logic             send_q;
  logic             take_byte, hs;

  assign take_byte = byte_we_i && !send_q && cnt_q != '0 && wr_q < cnt_q;
  assign hs        = send_q && m_ready_i;
  assign m_last_o  = send_q && (CNT_W'(rd_q) == cnt_q - CNT_W'(1));

  always_ff @(posedge clk_i) begin
    if (take_byte) mem[wr_q[IDX_W-1:0]] <= byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      send_q <= 1'b0;
    end else begin
      if (cnt_we_i && cnt_q == '0 && cnt_wdata_i != '0 && cnt_wdata_i <= 32'(DEPTH))
        cnt_q <= cnt_wdata_i[CNT_W-1:0];
      if (take_byte) begin
        wr_q <= wr_q + CNT_W'(1);
        if (wr_q + CNT_W'(1) == cnt_q) begin
          send_q <= 1'b1;
          rd_q   <= '0;
        end
      end
      if (hs) begin
        rd_q <= rd_q + IDX_W'(1);
        if (m_last_o) begin
          send_q <= 1'b0;
          cnt_q  <= '0;
          wr_q   <= '0;
        end
      end
    end
  end

  assign m_valid_o = send_q;
  assign m_data_o  = mem[rd_q];
  assign cnt_o     = cnt_q;
  assign done_o    = hs && m_last_o;
  assign sending_o = send_q;

  assert_tx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_last_o)));

  assert_tx_ignore_extra_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_q && !hs) |=> $stable(wr_q));
endmodule

// File: rtl/pkt_mailbox.sv
module pkt_mailbox
  import pkt_mailbox_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int ADDR_W   = 8,
  parameter int IRQ_LINE = 3,
  localparam int RX_CW = $clog2(RX_DEPTH + 1),
  localparam int TX_CW = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  logic             wr, rd;
  logic             wr_int, rd_int;
  logic [7:0]       rx_byte;
  logic [RX_CW-1:0] rx_cnt;
  logic [TX_CW-1:0] tx_cnt;
  logic             rx_held, rx_active, tx_done, tx_sending;
  logic             tx_done_q, test_flag_q, test_irq_q;
  logic [31:0]      rd_mux, rdata_q;

  assign wr     = bus_req_i && bus_we_i;
  assign rd     = bus_req_i && !bus_we_i;
  assign wr_int = wr && bus_addr_i == ADDR_W'(OFS_INTCTL);
  assign rd_int = rd && bus_addr_i == ADDR_W'(OFS_INTCTL);

  pmb_rx_path #(.DEPTH(RX_DEPTH)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_valid_i (rx_valid_i),
    .s_data_i  (rx_data_i),
    .s_last_i  (rx_last_i),
    .s_ready_o (rx_ready_o),
    .rd_en_i   (rd && bus_addr_i == ADDR_W'(OFS_RXDATA)),
    .release_i (wr_int && bus_wdata_i[INT_RXAVL]),
    .byte_o    (rx_byte),
    .cnt_o     (rx_cnt),
    .held_o    (rx_held),
    .active_o  (rx_active)
  );

  pmb_tx_path #(.DEPTH(TX_DEPTH)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_we_i    (wr && bus_addr_i == ADDR_W'(OFS_TXCNT)),
    .cnt_wdata_i (bus_wdata_i),
    .byte_we_i   (wr && bus_addr_i == ADDR_W'(OFS_TXDATA)),
    .byte_i      (bus_wdata_i[7:0]),
    .cnt_o       (tx_cnt),
    .m_valid_o   (tx_valid_o),
    .m_data_o    (tx_data_o),
    .m_last_o    (tx_last_o),
    .m_ready_i   (tx_ready_i),
    .done_o      (tx_done),
    .sending_o   (tx_sending)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_done_q   <= 1'b0;
      test_flag_q <= 1'b0;
      test_irq_q  <= 1'b0;
    end else begin
      if (tx_done) tx_done_q <= 1'b1;
      else if (wr_int && bus_wdata_i[INT_TXDONE]) tx_done_q <= 1'b0;
      if (wr_int && bus_wdata_i[INT_TEST]) test_flag_q <= 1'b1;
      else if (rd_int) test_flag_q <= 1'b0;
      if (wr_int && bus_wdata_i[INT_TEST]) test_irq_q <= 1'b1;
      else if (wr_int && bus_wdata_i == '0) test_irq_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr_i))
      OFS_BUSY:   rd_mux = {31'b0, rx_active || tx_sending};
      OFS_RXCNT:  rd_mux = 32'(rx_cnt);
      OFS_TXCNT:  rd_mux = 32'(tx_cnt);
      OFS_INTCTL: rd_mux = {test_flag_q, 29'b0, rx_held, tx_done_q};
      OFS_INFO:   rd_mux = 32'(IRQ_LINE);
      OFS_RXDATA: rd_mux = {24'b0, rx_byte};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = tx_done_q || rx_held || test_irq_q;

  assert_test_clear_on_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_int && test_flag_q) |=> !test_flag_q);

  assert_txdone_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_q) |-> ($past(tx_valid_o && tx_ready_i && tx_last_o) && tx_cnt == '0));

  assert_test_irq_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_irq_q && !wr_int) |=> irq_o);
endmodule

// File: tb/pkt_mailbox_bench.sv
module pkt_mailbox_bench;
  localparam int RXD = 64;
  localparam int TXD = 64;
  localparam int LINE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        irq;

  int checks = 0, failures = 0;
  int bp_mode = 0;
  int cyc = 0;
  logic [7:0] tx_exp_q[$];
  logic [7:0] rx_exp_q[$];

  always #2 clk = ~clk;

  pkt_mailbox #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .IRQ_LINE(LINE)) u_pkt_mailbox (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rx_ready_o(rx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (bp_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = (cyc % 3) != 0;
      default: tx_ready = 1'b0;
    endcase
  end

  // Stream model of the transmit side (R7)
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_exp_q.size() == 0) begin
        chk("R7 unexpected tx byte", {24'b0, tx_data}, 32'hFFFF_FFFF);
      end else begin
        chk("R7 tx last marker", {31'b0, tx_last}, {31'b0, tx_exp_q.size() == 1});
        chk("R7 tx byte order", {24'b0, tx_data}, {24'b0, tx_exp_q.pop_front()});
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic last);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_last = last;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic rx_frame(input int len, input int seed, input bit keep);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'(seed + i * 7);
      if (keep) rx_exp_q.push_back(b);
      rx_byte(b, i == len - 1);
    end
  endtask

  task automatic rx_drain(input string tag, input int n);
    for (int i = 0; i < n; i++) rd_chk(tag, 8'h1C, {24'b0, rx_exp_q.pop_front()});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    idle(3);
    // Reset state
    chk("R13 irq after reset", {31'b0, irq}, 0);
    chk("R5 rx_ready after reset", {31'b0, rx_ready}, 1);
    chk("R7 tx_valid after reset", {31'b0, tx_valid}, 0);
    rst_n = 1'b1;
    idle(2);
    rd_chk("R1 rx count reset", 8'h0C, 0);
    rd_chk("R1 tx count reset", 8'h10, 0);
    rd_chk("R1 intctl reset", 8'h14, 0);
    rd_chk("R11 busy reset", 8'h08, 0);
    rd_chk("R1 unmapped offset", 8'h04, 0);
    rd_chk("R12 info line", 8'h18, LINE);
    bus_wr(8'h18, 32'h55);
    rd_chk("R12 info after write", 8'h18, LINE);

    // Receive 5 bytes, partial drain
    rx_frame(5, 8'h30, 1);
    idle(2);
    rd_chk("R3 rx count loaded", 8'h0C, 5);
    rd_chk("R3 rx available bit", 8'h14, 32'h2);
    chk("R13 irq on rx", {31'b0, irq}, 1);
    chk("R5 ready low while held", {31'b0, rx_ready}, 0);
    rx_drain("R4 rx byte", 2);
    rd_chk("R4 count after two reads", 8'h0C, 3);
    rx_drain("R2 rx byte upper zero", 3);
    rd_chk("R4 count drained", 8'h0C, 0);
    rd_chk("R4 empty read", 8'h1C, 0);
    rd_chk("R4 count stays zero", 8'h0C, 0);

    // Offered frame while held
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h99; rx_last = 1'b1;
    idle(4);
    chk("R5 ready stays low", {31'b0, rx_ready}, 0);
    rx_valid = 1'b0; rx_last = 1'b0;
    rd_chk("R5 nothing accepted", 8'h0C, 0);
    bus_wr(8'h14, 32'h1);
    rd_chk("R9 bit0 write keeps bit1", 8'h14, 32'h2);
    bus_wr(8'h14, 32'h2);
    rd_chk("R9 bit1 cleared", 8'h14, 0);
    chk("R5 ready after release", {31'b0, rx_ready}, 1);
    chk("R13 irq clear", {31'b0, irq}, 0);

    // Busy during reception
    rx_exp_q.push_back(8'hA1); rx_byte(8'hA1, 0);
    rx_exp_q.push_back(8'hA2); rx_byte(8'hA2, 0);
    rx_exp_q.push_back(8'hA3); rx_byte(8'hA3, 0);
    rd_chk("R11 busy mid frame", 8'h08, 1);
    rx_exp_q.push_back(8'hA4); rx_byte(8'hA4, 1);
    rd_chk("R11 busy after frame", 8'h08, 0);
    rd_chk("R3 count 4", 8'h0C, 4);
    rx_drain("R4 rx byte second frame", 4);
    bus_wr(8'h14, 32'h2);

    // Oversized frame dropped, full-depth frame delivered
    rx_frame(RXD + 1, 8'h11, 0);
    idle(2);
    rd_chk("R6 oversize no flag", 8'h14, 0);
    rd_chk("R6 oversize no count", 8'h0C, 0);
    chk("R6 ready after drop", {31'b0, rx_ready}, 1);
    rd_chk("R11 busy after drop", 8'h08, 0);
    rx_frame(RXD, 8'h05, 1);
    idle(2);
    rd_chk("R6 full depth count", 8'h0C, RXD);
    rx_drain("R6 full depth byte", RXD);
    bus_wr(8'h14, 32'h2);

    // Transmit with backpressure
    bp_mode = 1;
    bus_wr(8'h10, 4);
    for (int i = 0; i < 3; i++) begin
      tx_exp_q.push_back(8'(8'hC0 + i));
      bus_wr(8'h20, 32'(8'hC0 + i));
    end
    idle(3);
    chk("R7 no send before count reached", {31'b0, tx_valid}, 0);
    rd_chk("R7 tx count held", 8'h10, 4);
    tx_exp_q.push_back(8'hC3);
    bus_wr(8'h20, 32'hC3);
    idle(20);
    chk("R7 all tx bytes sent", tx_exp_q.size(), 0);
    rd_chk("R8 tx count cleared", 8'h10, 0);
    rd_chk("R8 tx done bit", 8'h14, 32'h1);
    chk("R13 irq on tx done", {31'b0, irq}, 1);
    bus_wr(8'h14, 32'h1);
    rd_chk("R9 tx done cleared", 8'h14, 0);

    // Extra writes ignored, count rewrite ignored, busy while sending
    bp_mode = 2;
    bus_wr(8'h10, 2);
    tx_exp_q.push_back(8'h61); bus_wr(8'h20, 32'h61);
    tx_exp_q.push_back(8'h62); bus_wr(8'h20, 32'h62);
    bus_wr(8'h20, 32'hEE);
    bus_wr(8'h10, 5);
    rd_chk("R7 count write ignored while pending", 8'h10, 2);
    rd_chk("R11 busy while sending", 8'h08, 1);
    bp_mode = 0;
    idle(8);
    chk("R7 two bytes sent", tx_exp_q.size(), 0);
    rd_chk("R11 busy after send", 8'h08, 0);
    bus_wr(8'h14, 32'h1);

    // Range limit and upper-bit masking
    bus_wr(8'h10, TXD + 1);
    rd_chk("R7 oversize count ignored", 8'h10, 0);
    bus_wr(8'h10, 1);
    tx_exp_q.push_back(8'h5A);
    bus_wr(8'h20, 32'hFFFF_FF5A);
    idle(6);
    chk("R2 tx low byte only", tx_exp_q.size(), 0);
    bus_wr(8'h14, 32'h1);

    // Self-test bit
    bus_wr(8'h14, 32'h8000_0000);
    chk("R10 test irq raised", {31'b0, irq}, 1);
    rd_chk("R10 first read shows bit31", 8'h14, 32'h8000_0000);
    rd_chk("R10 second read clear", 8'h14, 0);
    chk("R10 irq held after read", {31'b0, irq}, 1);
    bus_wr(8'h14, 32'h0);
    chk("R13 irq dropped after zero write", {31'b0, irq}, 0);

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule